// File: doc/BRIEF.md
# Truncated Rice Binarizer

This block turns an unsigned syntax value into a truncated Rice bin string and its length, one result per clock, for use at the front of an entropy coder. Three inputs set the conversion: the value, a cap on the prefix count, and a Rice parameter `k`. The prefix count is the value shifted right by `k`. It is sent as a run of ones. The run ends in a zero unless the count has reached the cap. The low `k` bits of the value then follow as a fixed-width suffix, most significant bit first.

The result is a 32-bit string, left-aligned, together with the number of valid bins. Both are registered once and flagged by an output strobe one clock after the input strobe. A Rice parameter of zero reduces the block to a plain truncated unary coder. Legal inputs are `k` from 0 to 4 and a cap from 1 to 8, so a string holds at most 12 bins.

Top module: `trice_bin`

## Requirements
- R1: With prefix count p = value >> k below the cap, the string starts with p ones followed by a single zero, so the prefix takes p+1 bins.
- R2: With p equal to the cap, the prefix is exactly p ones with no terminating zero, and the length is p + k.
- R3: With p above the cap, the prefix saturates to cap ones with no terminating zero, and the suffix is still the low k bits of the value.
- R4: The suffix is the low k bits of the value, placed right after the prefix, most significant bit first.
- R5: With k = 0 there is no suffix and the output is the truncated unary code of the value against the cap.
- R6: Bin index 0 is in bit 31 of the string, and every bit below the last valid bin is zero.
- R7: String, length and output valid appear on the clock edge after the input valid is sampled high, and the output valid is low after a cycle with input valid low.
- R8: While the input valid is low, the string and length keep their previous values.
- R9: A synchronous active-high reset clears the string, the length and the output valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | Input strobe |
| i_val | input | 8 | Unsigned syntax value |
| i_max | input | 4 | Prefix count cap, 1 to 8 |
| i_k | input | 3 | Rice parameter, 0 to 4 |
| o_valid | output | 1 | Result strobe, one cycle after i_valid |
| o_bins | output | 32 | Left-aligned bin string, bin 0 in bit 31 |
| o_len | output | 6 | Number of valid bins |

## Verification
A table of vectors drives the prefix count below the cap, equal to it and above it, so a missing or extra terminating zero, or a missing saturation, shows up in both the string and the length. The Rice parameter is swept over 0, 1, 2, 3 and 4 with suffix patterns of all zeros, all ones and mixed bits, which separates a wrong suffix width or bit order from a wrong position after the prefix. Further tests drop the strobe while the value changes, to show that the outputs hold, and assert reset in the middle of a run.

// File: rtl/trice_bin.sv
module trice_bin #(
  parameter int VAL_W  = 8,
  parameter int MAXP_W = 4,
  parameter int K_W    = 3,
  parameter int STR_W  = 32,
  parameter int LEN_W  = $clog2(STR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_valid,
  input  logic [VAL_W-1:0]  i_val,
  input  logic [MAXP_W-1:0] i_max,
  input  logic [K_W-1:0]    i_k,
  output logic              o_valid,
  output logic [STR_W-1:0]  o_bins,
  output logic [LEN_W-1:0]  o_len
);

  localparam logic [STR_W-1:0] ALL1 = '1;

  logic [VAL_W-1:0] pfx_raw, cap, pfx;
  logic             at_cap;
  logic [LEN_W-1:0] len_n;
  logic [STR_W-1:0] ones, sfx, bins_n;

  assign pfx_raw = i_val >> i_k;
  assign cap     = VAL_W'(i_max);
  assign at_cap  = pfx_raw >= cap;
  assign pfx     = at_cap ? cap : pfx_raw;

  assign len_n = LEN_W'(pfx) + {{(LEN_W-1){1'b0}}, ~at_cap} + LEN_W'(i_k);

  assign ones   = ~(ALL1 >> pfx);
  assign sfx    = STR_W'(i_val) & ~(ALL1 << i_k);
  assign bins_n = ones | (sfx << (LEN_W'(STR_W) - len_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_bins  <= '0;
      o_len   <= '0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_bins <= bins_n;
        o_len  <= len_n;
      end
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> o_valid);

  a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> !o_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> ($stable(o_bins) && $stable(o_len)));

  a_r6_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (o_bins & (ALL1 >> o_len)) == '0);

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!o_valid && o_bins == '0 && o_len == '0));

endmodule

// File: tb/trice_bin_tb.sv
module trice_bin_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_valid = 1'b0;
  logic [7:0]  i_val = '0;
  logic [3:0]  i_max = 4'd1;
  logic [2:0]  i_k = '0;
  logic        o_valid;
  logic [31:0] o_bins;
  logic [5:0]  o_len;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  trice_bin u_dut (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_val(i_val),
    .i_max(i_max), .i_k(i_k), .o_valid(o_valid), .o_bins(o_bins), .o_len(o_len)
  );

  // {value, cap, k, expected string, expected length, requirement tag}
  localparam int NV = 15;
  localparam logic [52:0] VEC [NV] = '{
    {8'd0,   4'd4, 3'd0, 32'h00000000, 6'd1},   // R1 R5
    {8'd3,   4'd5, 3'd0, 32'hE0000000, 6'd4},   // R1 R5
    {8'd5,   4'd5, 3'd0, 32'hF8000000, 6'd5},   // R2 R5
    {8'd7,   4'd5, 3'd0, 32'hF8000000, 6'd5},   // R3 R5
    {8'd6,   4'd4, 3'd1, 32'hE0000000, 6'd5},   // R1 R4
    {8'd7,   4'd4, 3'd1, 32'hE8000000, 6'd5},   // R4
    {8'd14,  4'd3, 3'd2, 32'hF0000000, 6'd5},   // R2 R4
    {8'd0,   4'd1, 3'd4, 32'h00000000, 6'd5},   // R1 R4
    {8'd31,  4'd1, 3'd4, 32'hF8000000, 6'd5},   // R2 R4
    {8'd143, 4'd8, 3'd4, 32'hFFF00000, 6'd12},  // R2 R6
    {8'd200, 4'd8, 3'd4, 32'hFF800000, 6'd12},  // R3 R4
    {8'd37,  4'd8, 3'd3, 32'hF5000000, 6'd8},   // R1 R4
    {8'd9,   4'd6, 3'd2, 32'hC8000000, 6'd5},   // R1 R4
    {8'd1,   4'd2, 3'd0, 32'h80000000, 6'd2},   // R1 R6
    {8'd255, 4'd8, 3'd0, 32'hFF000000, 6'd8}    // R3 R5
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 reset valid", 64'(o_valid), 64'd0);
    check("R9 reset bins", 64'(o_bins), 64'd0);
    check("R9 reset len", 64'(o_len), 64'd0);

    for (int n = 0; n < NV; n++) begin
      i_val   = VEC[n][52:45];
      i_max   = VEC[n][44:41];
      i_k     = VEC[n][40:38];
      i_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R1-R6 vec%0d bins (r1_ r2_ r3_ r4_ r5_ r6_)", n), 64'(o_bins), 64'(VEC[n][37:6]));
      check($sformatf("R2 vec%0d len", n), 64'(o_len), 64'(VEC[n][5:0]));
      check("R7 valid", 64'(o_valid), 64'd1);
    end

    // R8: strobe low, inputs change, outputs hold the last result
    i_valid = 1'b0;
    i_val   = 8'd2;
    i_max   = 4'd3;
    i_k     = 3'd0;
    @(negedge clk);
    check("R7 valid low", 64'(o_valid), 64'd0);
    check("R8 hold bins", 64'(o_bins), 64'hFF000000);
    check("R8 hold len", 64'(o_len), 64'd8);

    // R7: new result arrives exactly one edge after strobe
    i_valid = 1'b1;
    @(negedge clk);
    i_valid = 1'b0;
    check("R7 one-cycle bins", 64'(o_bins), 64'hC0000000);
    check("R7 one-cycle len", 64'(o_len), 64'd3);
    @(negedge clk);
    check("R7 strobe pulse", 64'(o_valid), 64'd0);

    // R9: reset mid-run
    i_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset valid", 64'(o_valid), 64'd0);
    check("R9 mid reset bins", 64'(o_bins), 64'd0);
    check("R9 mid reset len", 64'(o_len), 64'd0);
    rst = 1'b0;
    i_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule